// File: doc/BRIEF.md
# Serial Port Status Flag Controller

This block keeps the status byte of an asynchronous serial port and owns the set and clear rules for each of its seven flags. It does not move characters. The transmitter reports two events: its holding buffer has emptied, and its shifter has gone idle. The receiver reports three things: a character has completed (with the sampled stop bit), the three-sample vote on each bit, and the level of a line-idle detector. A wake-up control level from the receiver configuration also comes in. The bus side gives one-cycle strobes that select the status register or the data register, together with read and write qualifiers.

A flag is never cleared by a write of ones. A flag clears in two steps. First the status register is read while that flag is set, which arms the flag. Then a later access to the data register clears it. A data write clears the two transmit flags, and a data read clears the five receive flags. Each status read replaces the arming with the flags as they stand at that read. A flag that sets after the read therefore survives the following data access. When a set event and a clear fall in the same cycle, the flag stays set.

The receive side holds the old character when an overrun happens. The noise and framing flags are loaded only when a character is actually taken into the data register. The line-idle flag re-arms only after the line has been seen active.

Top module: `uart_status_flags`

## Requirements
- R1: `status` bit 7 is transmit-buffer-empty, bit 6 is transmit-complete, bit 5 is receive-full, bit 4 is line-idle, bit 3 is overrun, bit 2 is noise and bit 1 is framing error. Bit 0 always reads 0.
- R2: After reset `status` is 8'hC0: the two transmit flags are set and all others are clear.
- R3: `tx_buf_empty` sets bit 7 and `tx_idle` sets bit 6 on the next clock. Each clears only on a data-register write (`bus_sel_data` & `bus_wr`) that follows a status read (`bus_sel_status` & `bus_rd`) that saw it set.
- R4: Bits 5 to 1 each clear only on a data-register read (`bus_sel_data` & `bus_rd`) that follows a status read that saw that bit set.
- R5: `rx_char_done` always sets bit 5. When bit 5 is already set at that event, bit 3 is set instead of taking the character.
- R6: Bit 2 sets when a character is taken into the data register (`rx_char_done` while bit 5 is clear) and some `rx_votes` sample triple during that frame was not all-equal. This includes a triple given in the `rx_char_done` cycle itself.
- R7: Bit 1 sets when a character is taken into the data register with `rx_stop_bit` = 0.
- R8: Bit 4 sets when `rx_line_idle` is high after having been low since the last time bit 4 was set. A line that has been idle since reset, or idle ever since the last setting, does not set it.
- R9: While `wake_en` = 1, bit 4 does not set.
- R10: Arming is taken at the status read. A flag that was clear at that read is not cleared by the following data access, even if it set in between.
- R11: When a set event and a qualifying clear of the same flag fall in the same cycle, the flag stays set.
- R12: A data-register access without a preceding arming status read leaves every flag unchanged.
- R13: On an overrun, bits 2 and 1 are not changed by the dropped character's votes or stop bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_buf_empty | input | 1 | Pulse: transmit holding buffer emptied |
| tx_idle | input | 1 | Pulse: transmitter has nothing in progress |
| rx_char_done | input | 1 | Pulse: a received character is complete |
| rx_stop_bit | input | 1 | Voted stop-bit value, valid with rx_char_done |
| rx_vote_vld | input | 1 | rx_votes holds the samples of one bit |
| rx_votes | input | VOTES | Samples taken on one received bit |
| rx_line_idle | input | 1 | Level: receive line currently idle |
| wake_en | input | 1 | Level: wake-up mode, blocks the line-idle flag |
| bus_sel_status | input | 1 | Strobe: status register selected |
| bus_sel_data | input | 1 | Strobe: data register selected |
| bus_rd | input | 1 | Access is a read |
| bus_wr | input | 1 | Access is a write |
| status | output | 8 | Status byte |

## Verification
The bench goes after the arming window. It sets a flag after the status read and expects that flag to survive the data access. A design that armed at the data access instead would clear a character that nobody had seen. It drives set and clear in the same cycle: a design that let the clear win would lose a received character or transmit event. It sends a second character onto an unread one carrying noise and a bad stop bit. A design that loaded those on overrun would report errors for a dropped character. It holds the line idle after clearing the idle flag, and also raises wake-up mode. A design without edge re-arming would set the flag again at once, and a design that ignored wake-up mode would set it while blocked. Data accesses with no prior status read must leave everything untouched.

// File: rtl/uart_sts_pkg.sv
// Shared constants for the serial status flag controller.
// Flag vector index i maps to status bit i+1.
package uart_sts_pkg;
    localparam int NFLAG   = 7;
    localparam int FI_TDRE = 6;
    localparam int FI_TC   = 5;
    localparam int FI_RDRF = 4;
    localparam int FI_IDLE = 3;
    localparam int FI_OR   = 2;
    localparam int FI_NF   = 1;
    localparam int FI_FE   = 0;
    // Reset image: transmit flags set, receive flags clear.
    localparam logic [NFLAG-1:0] RST_FLAGS   = 7'b1100000;
    // Flags cleared by a data write; the rest clear on a data read.
    localparam logic [NFLAG-1:0] WR_CLR_MASK = 7'b1100000;
endpackage

// File: rtl/uart_sts_flag.sv
// One status flag: set-dominant register with a clear request.
// Assumes set and clr are single-cycle qualified requests.
module uart_sts_flag #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic q
);
    // Hold, set (winning over clear) or clear the flag.
    always_ff @(posedge clk) begin
        if (!rst_n)   q <= RST_VAL;
        else if (set) q <= 1'b1;
        else if (clr) q <= 1'b0;
    end
endmodule

// File: rtl/uart_sts_arm.sv
// Two-step clear sequencer: a status read captures which flags are set,
// a later data access of the matching kind consumes those arms.
// Assumes bus strobes last one cycle per access.
module uart_sts_arm
    import uart_sts_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sts_rd,
    input  logic             dat_rd,
    input  logic             dat_wr,
    input  logic [NFLAG-1:0] flags,
    output logic [NFLAG-1:0] clr
);
    logic [NFLAG-1:0] arm_q;
    logic [NFLAG-1:0] kind;

    // Which flags the current data access may clear.
    always_comb begin
        kind = '0;
        if (dat_wr) kind = kind | WR_CLR_MASK;
        if (dat_rd) kind = kind | ~WR_CLR_MASK;
    end

    assign clr = arm_q & kind;

    // Capture arms at a status read, drop them once consumed.
    always_ff @(posedge clk) begin
        if (!rst_n)      arm_q <= '0;
        else if (sts_rd) arm_q <= flags;
        else             arm_q <= arm_q & ~kind;
    end
endmodule

// File: rtl/uart_sts_rx.sv
// Receive event decoder: turns character, vote and line-level events
// into set requests for the receive flags. Noise is accumulated over a
// frame; the idle flag re-arms only after the line was seen active.
module uart_sts_rx #(
    parameter int VOTES = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_char_done,
    input  logic             rx_stop_bit,
    input  logic             rx_vote_vld,
    input  logic [VOTES-1:0] rx_votes,
    input  logic             rx_line_idle,
    input  logic             wake_en,
    input  logic             rdrf_q,
    output logic             set_rdrf,
    output logic             set_or,
    output logic             set_nf,
    output logic             set_fe,
    output logic             set_idle
);
    logic noise_now;
    logic noise_acc;
    logic idle_armed;
    logic take;

    assign noise_now = rx_vote_vld && !((&rx_votes) || !(|rx_votes));
    assign take      = rx_char_done && !rdrf_q;
    assign set_rdrf  = rx_char_done;
    assign set_or    = rx_char_done && rdrf_q;
    assign set_nf    = take && (noise_acc || noise_now);
    assign set_fe    = take && !rx_stop_bit;
    assign set_idle  = idle_armed && rx_line_idle && !wake_en;

    // Remember any split vote within the current frame.
    always_ff @(posedge clk) begin
        if (!rst_n)            noise_acc <= 1'b0;
        else if (rx_char_done) noise_acc <= 1'b0;
        else if (noise_now)    noise_acc <= 1'b1;
    end

    // Re-arm idle detection when the line is active, disarm on setting.
    always_ff @(posedge clk) begin
        if (!rst_n)            idle_armed <= 1'b0;
        else if (!rx_line_idle) idle_armed <= 1'b1;
        else if (set_idle)     idle_armed <= 1'b0;
    end
endmodule

// File: rtl/uart_status_flags.sv
// Serial port status byte: seven set-dominant flags with a two-step
// (status read, then data access) clear. Bit 0 reads zero.
// Assumes all event and bus inputs are synchronous to clk.
module uart_status_flags
    import uart_sts_pkg::*;
#(
    parameter int VOTES = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_buf_empty,
    input  logic             tx_idle,
    input  logic             rx_char_done,
    input  logic             rx_stop_bit,
    input  logic             rx_vote_vld,
    input  logic [VOTES-1:0] rx_votes,
    input  logic             rx_line_idle,
    input  logic             wake_en,
    input  logic             bus_sel_status,
    input  logic             bus_sel_data,
    input  logic             bus_rd,
    input  logic             bus_wr,
    output logic [7:0]       status
);
    logic [NFLAG-1:0] flags;
    logic [NFLAG-1:0] set_v;
    logic [NFLAG-1:0] clr_v;
    logic s_rdrf, s_or, s_nf, s_fe, s_idle;

    uart_sts_rx #(.VOTES(VOTES)) u_rx (
        .clk(clk), .rst_n(rst_n),
        .rx_char_done(rx_char_done), .rx_stop_bit(rx_stop_bit),
        .rx_vote_vld(rx_vote_vld), .rx_votes(rx_votes),
        .rx_line_idle(rx_line_idle), .wake_en(wake_en),
        .rdrf_q(flags[FI_RDRF]),
        .set_rdrf(s_rdrf), .set_or(s_or), .set_nf(s_nf),
        .set_fe(s_fe), .set_idle(s_idle)
    );

    uart_sts_arm u_arm (
        .clk(clk), .rst_n(rst_n),
        .sts_rd(bus_sel_status && bus_rd),
        .dat_rd(bus_sel_data && bus_rd),
        .dat_wr(bus_sel_data && bus_wr),
        .flags(flags),
        .clr(clr_v)
    );

    // Gather set requests into flag-vector order.
    always_comb begin
        set_v          = '0;
        set_v[FI_TDRE] = tx_buf_empty;
        set_v[FI_TC]   = tx_idle;
        set_v[FI_RDRF] = s_rdrf;
        set_v[FI_IDLE] = s_idle;
        set_v[FI_OR]   = s_or;
        set_v[FI_NF]   = s_nf;
        set_v[FI_FE]   = s_fe;
    end

    for (genvar i = 0; i < NFLAG; i++) begin : g_flag
        uart_sts_flag #(.RST_VAL(RST_FLAGS[i])) u_flag (
            .clk(clk), .rst_n(rst_n),
            .set(set_v[i]), .clr(clr_v[i]), .q(flags[i])
        );
    end

    assign status = {flags, 1'b0};
endmodule

// File: rtl/uart_status_flags_chk.sv
// Property checker for uart_status_flags, attached by bind.
module uart_status_flags_chk #(
    parameter int VOTES = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tx_buf_empty,
    input logic             tx_idle,
    input logic             rx_char_done,
    input logic             rx_stop_bit,
    input logic             rx_vote_vld,
    input logic [VOTES-1:0] rx_votes,
    input logic             rx_line_idle,
    input logic             wake_en,
    input logic             bus_sel_status,
    input logic             bus_sel_data,
    input logic             bus_rd,
    input logic             bus_wr,
    input logic [7:0]       status
);
    assert_bit0_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        status[0] == 1'b0);

    assert_tdre_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_buf_empty |=> status[7]);

    assert_tdre_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(status[7] && !(bus_sel_data && bus_wr)) |-> status[7]);

    assert_rdrf_set_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rx_char_done |=> status[5]);

    assert_or_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (status[3] && !$past(status[3])) |-> $past(rx_char_done && status[5]));

    assert_rdrf_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $past(status[5] && !(bus_sel_data && bus_rd)) |-> status[5]);

    assert_idle_blocked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wake_en && !status[4]) |-> !status[4]);
endmodule

bind uart_status_flags uart_status_flags_chk #(.VOTES(VOTES)) u_chk (.*);

// File: tb/test_uart_status_flags.sv
// Self-checking bench: directed corner cases, then seeded random traffic,
// all compared against a cycle model built from the requirements.
module test_uart_status_flags;
    localparam int VOTES = 3;
    localparam logic [6:0] WMASK = 7'b1100000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_buf_empty = 0, tx_idle = 0, rx_char_done = 0, rx_stop_bit = 1;
    logic rx_vote_vld = 0;
    logic [VOTES-1:0] rx_votes = '0;
    logic rx_line_idle = 1, wake_en = 0;
    logic bus_sel_status = 0, bus_sel_data = 0, bus_rd = 0, bus_wr = 0;
    logic [7:0] status;

    int n_chk = 0;
    int n_bad = 0;

    // Model state.
    logic [6:0] m_f;
    logic [6:0] m_arm;
    logic m_noise, m_iarm;

    uart_status_flags #(.VOTES(VOTES)) i_uart_status_flags (.*);

    always #5 clk = ~clk;

    // Status byte expected from a model flag vector.
    function automatic logic [7:0] exp_status(input logic [6:0] f);
        return {f, 1'b0};
    endfunction

    // True when a vote triple is split.
    function automatic logic split(input logic v, input logic [VOTES-1:0] s);
        return v && !((&s) || !(|s));
    endfunction

    // Advance the model by one clock using the current inputs.
    task automatic model_step();
        logic srd, drd, dwr, take, nz, sidle;
        logic [6:0] clr, set;
        srd = bus_sel_status && bus_rd;
        drd = bus_sel_data && bus_rd;
        dwr = bus_sel_data && bus_wr;
        clr = m_arm & ((dwr ? WMASK : 7'b0) | (drd ? ~WMASK : 7'b0));
        nz = split(rx_vote_vld, rx_votes);
        take = rx_char_done && !m_f[4];
        sidle = m_iarm && rx_line_idle && !wake_en;
        set = {tx_buf_empty, tx_idle, rx_char_done, sidle,
               rx_char_done && m_f[4], take && (m_noise || nz),
               take && !rx_stop_bit};
        if (srd) m_arm = m_f;
        else m_arm = m_arm & ~(clr | ((dwr ? WMASK : 7'b0) | (drd ? ~WMASK : 7'b0)));
        m_f = (m_f & ~clr) | set;
        if (rx_char_done) m_noise = 1'b0;
        else if (nz) m_noise = 1'b1;
        if (!rx_line_idle) m_iarm = 1'b1;
        else if (sidle) m_iarm = 1'b0;
    endtask

    task automatic check(input string tag, input logic [7:0] exp);
        n_chk++;
        if (status !== exp) begin
            n_bad++;
            $display("FAIL %s: status=%h expected=%h", tag, status, exp);
        end
    endtask

    // Apply current inputs for one clock, compare, then drop pulses.
    task automatic tick(input string tag);
        model_step();
        @(posedge clk);
        @(negedge clk);
        check(tag, exp_status(m_f));
        tx_buf_empty = 0; tx_idle = 0; rx_char_done = 0; rx_vote_vld = 0;
        bus_sel_status = 0; bus_sel_data = 0; bus_rd = 0; bus_wr = 0;
        rx_stop_bit = 1;
    endtask

    task automatic sts_read(input string tag);
        bus_sel_status = 1; bus_rd = 1; tick(tag);
    endtask
    task automatic dat_read(input string tag);
        bus_sel_data = 1; bus_rd = 1; tick(tag);
    endtask
    task automatic dat_write(input string tag);
        bus_sel_data = 1; bus_wr = 1; tick(tag);
    endtask

    initial begin
        #2_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: timeout actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] seed;
        seed = 32'd12345;
        void'($urandom(seed));
        m_f = 7'b1100000; m_arm = '0; m_noise = 0; m_iarm = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        check("R2 reset value, R1 bit0", 8'hC0);

        // R12: data accesses without status read change nothing.
        dat_write("R12 write without arm");
        dat_read("R12 read without arm");
        check("R12 flags untouched", 8'hC0);

        // R3: two-step clear of transmit flags, then set events.
        sts_read("R3 status read");
        dat_write("R3 data write clears TDRE/TC");
        check("R3 cleared", 8'h00);
        tx_buf_empty = 1; tick("R3 TDRE set");
        tx_idle = 1; tick("R3 TC set");
        check("R3 both set", 8'hC0);

        // R10: flag set after status read survives the data read.
        sts_read("R10 read with RDRF clear");
        rx_char_done = 1; tick("R5 RDRF set");
        dat_read("R10 late RDRF not cleared");
        check("R10 RDRF kept", 8'hE0);
        sts_read("R4 arm RDRF");
        dat_read("R4 RDRF cleared");
        check("R4 RDRF clear", 8'hC0);

        // R11: set and clear in the same cycle, set wins.
        rx_char_done = 1; tick("R5 RDRF set again");
        sts_read("R11 arm");
        bus_sel_data = 1; bus_rd = 1; rx_char_done = 1;
        tick("R11 set wins, R5 overrun");
        check("R11 RDRF and OR set", 8'hE8);
        sts_read("R4 arm RDRF OR");
        dat_read("R4 clear RDRF OR");
        check("R4 all rx clear", 8'hC0);

        // R13: overrun drops noise and stop bit of the new character.
        rx_char_done = 1; tick("R5 first char");
        rx_vote_vld = 1; rx_votes = 3'b010; tick("R13 noisy vote");
        rx_char_done = 1; rx_stop_bit = 0; tick("R13 overrun char");
        check("R13 NF FE unchanged", 8'hE8);
        sts_read("R4 arm");
        dat_read("R4 clear");

        // R6: noise during frame sets NF on transfer.
        rx_vote_vld = 1; rx_votes = 3'b110; tick("R6 split vote");
        rx_vote_vld = 1; rx_votes = 3'b111; tick("R6 unanimous vote");
        rx_char_done = 1; tick("R6 transfer");
        check("R6 NF set", 8'hE4);
        sts_read("R4 arm NF");
        dat_read("R4 clear NF");
        // R7: bad stop bit sets FE.
        rx_char_done = 1; rx_stop_bit = 0; tick("R7 transfer bad stop");
        check("R7 FE set", 8'hE2);
        sts_read("R4 arm FE");
        dat_read("R4 clear FE");
        check("R4 FE clear", 8'hC0);

        // R8: idle needs line activity first.
        tick("R8 idle since reset");
        check("R8 no idle without activity", 8'hC0);
        rx_line_idle = 0; tick("R8 line active");
        rx_line_idle = 1; tick("R8 line idle");
        check("R8 IDLE set", 8'hD0);
        sts_read("R4 arm IDLE");
        dat_read("R4 clear IDLE");
        repeat (4) tick("R8 stays clear while idle");
        check("R8 no re-set", 8'hC0);

        // R9: wake-up mode blocks IDLE.
        wake_en = 1;
        rx_line_idle = 0; tick("R9 active");
        rx_line_idle = 1; tick("R9 idle with wake");
        tick("R9 still blocked");
        check("R9 IDLE blocked", 8'hC0);
        wake_en = 0;

        // Seeded random traffic.
        for (int k = 0; k < 4000; k++) begin
            logic [31:0] r;
            r = $urandom;
            tx_buf_empty = (r[3:0] == 0);
            tx_idle      = (r[7:4] == 0);
            rx_char_done = (r[10:8] == 0);
            rx_stop_bit  = (r[12:11] != 0);
            rx_vote_vld  = r[13];
            rx_votes     = r[16:14];
            if (r[21:18] == 0) rx_line_idle = ~rx_line_idle;
            if (r[27:22] == 0) wake_en = ~wake_en;
            case (r[30:28])
                3'd0: begin bus_sel_status = 1; bus_rd = 1; end
                3'd1: begin bus_sel_data = 1; bus_rd = 1; end
                3'd2: begin bus_sel_data = 1; bus_wr = 1; end
                3'd3: begin bus_sel_status = 1; bus_rd = 1; end
                default: ;
            endcase
            tick("R3 R4 random");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule